// File: doc/BRIEF.md
# Branch Direction Predictor with Per-Branch Not-Taken History

This block guesses, in the same cycle, whether a conditional branch will be taken. It keeps a direct-mapped table. The low bits of the branch address select a slot. The remaining upper bits are stored as a tag, so a slot recognises only the branch that filled it.

When the table holds no entry for a branch, a static rule decides from the jump direction: a backward jump is assumed to close a loop and is predicted taken, and a forward jump is predicted not taken. When the table does hold the branch, each entry keeps a 2-bit count of the resolutions seen since the branch was last taken. The branch is predicted taken while that count is below its maximum. A single not-taken resolution, such as an inner loop exit, therefore does not flip the next guess.

Resolved branches come back through an update port. That port either refreshes the matching entry or claims the slot for a new branch.

Top module: `bdp_top`

## Requirements
- R1: A synchronous reset invalidates every slot, so every lookup in the cycle after reset reports a miss (`lk_hit`=0).
- R2: A lookup that misses with `lk_backward`=0 (forward jump) gives `lk_taken`=0.
- R3: A lookup that misses with `lk_backward`=1 (backward jump) gives `lk_taken`=1.
- R4: A lookup that hits an entry whose history is 0, 1 or 2 gives `lk_taken`=1, whatever `lk_backward` is.
- R5: A lookup that hits an entry whose history is 3 gives `lk_taken`=0, whatever `lk_backward` is.
- R6: An update with `upd_taken`=1 that hits an entry sets that entry's history to 0.
- R7: An update with `upd_taken`=0 that hits an entry adds one to its history. Once the history is 3 it stays at 3.
- R8: An update that misses claims the slot and writes the tag. It starts the history at 0 when taken and at 1 when not taken, so a lookup of that address in the next cycle hits.
- R9: The slot is `pc[IDX_W-1:0]` and the tag is `pc[PC_W-1:IDX_W]`. An address whose tag differs from the stored one misses. An update from it replaces the entry, after which the earlier address misses.
- R10: A lookup and an update to the same slot in one cycle return the contents from before the update. The update is seen from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | PC_W | Address of the branch being predicted |
| lk_backward | input | 1 | 1 when the branch target lies below the branch |
| lk_hit | output | 1 | 1 when a valid entry with a matching tag was found |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench builds the block with `PC_W`=8 and `ENTRIES`=8. This gives eight slots and a 5-bit tag, so all 256 addresses can be swept in both directions right after reset. Aliasing pairs that share a slot are easy to write at this size, and saturation is reached within a few updates. On top of that, the bench replays nested-loop and alternating forward-branch traces. Some of those traces look up and update the same address in one cycle. Every guess is compared with a reference table kept in the bench.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

  typedef logic [1:0] hist_t;

  localparam hist_t HIST_MAX = 2'b11;

  // history after a resolution on an existing entry
  function automatic hist_t hist_step(input hist_t h, input logic taken);
    hist_t n;
    if (taken)              n = '0;
    else if (h == HIST_MAX) n = HIST_MAX;
    else                    n = h + hist_t'(1);
    return n;
  endfunction

  // history given to a freshly claimed slot
  function automatic hist_t hist_alloc(input logic taken);
    return taken ? hist_t'(0) : hist_t'(1);
  endfunction

  // direction guess from table state and static fallback
  function automatic logic dir_guess(input logic hit, input hist_t h,
                                     input logic backward);
    logic g;
    if (hit) g = (h != HIST_MAX);
    else     g = backward;
    return g;
  endfunction

endpackage

// File: rtl/bdp_table.sv
module bdp_table
  import bdp_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 10,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] ra_idx,
  output logic             ra_valid,
  output logic [TAG_W-1:0] ra_tag,
  output hist_t            ra_hist,
  input  logic [IDX_W-1:0] rb_idx,
  output logic             rb_valid,
  output logic [TAG_W-1:0] rb_tag,
  output hist_t            rb_hist,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  hist_t            wr_hist
);

  logic             valid_q [ENTRIES];
  logic [TAG_W-1:0] tag_q   [ENTRIES];
  hist_t            hist_q  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)                                  valid_q[e] <= 1'b0;
      else if (wr_en && wr_idx == IDX_W'(e))   valid_q[e] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      hist_q[wr_idx] <= wr_hist;
    end
  end

  assign ra_valid = valid_q[ra_idx];
  assign ra_tag   = tag_q[ra_idx];
  assign ra_hist  = hist_q[ra_idx];
  assign rb_valid = valid_q[rb_idx];
  assign rb_tag   = tag_q[rb_idx];
  assign rb_hist  = hist_q[rb_idx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(wr_idx)] && hist_q[$past(wr_idx)] == $past(wr_hist)
              && tag_q[$past(wr_idx)] == $past(wr_tag)); // R8

endmodule

// File: rtl/bdp_lookup.sv
module bdp_lookup
  import bdp_pkg::*;
#(
  parameter int TAG_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ent_valid,
  input  logic [TAG_W-1:0] ent_tag,
  input  hist_t            ent_hist,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             backward,
  output logic             hit,
  output logic             taken
);

  assign hit   = ent_valid && (ent_tag == req_tag);
  assign taken = dir_guess(hit, ent_hist, backward);

  AST_MISS_STATIC: assert property (@(posedge clk) disable iff (rst)
    !ent_valid |-> taken == backward); // R3

endmodule

// File: rtl/bdp_update.sv
module bdp_update
  import bdp_pkg::*;
#(
  parameter int TAG_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_valid,
  input  logic             upd_taken,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic             old_valid,
  input  logic [TAG_W-1:0] old_tag,
  input  hist_t            old_hist,
  output logic             upd_hit,
  output logic             wr_en,
  output hist_t            wr_hist
);

  assign upd_hit = old_valid && (old_tag == upd_tag);
  assign wr_en   = upd_valid;
  assign wr_hist = upd_hit ? hist_step(old_hist, upd_taken) : hist_alloc(upd_taken);

  AST_TAKEN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    upd_valid && upd_taken |-> wr_hist == 2'd0); // R6

  AST_NOT_TAKEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    upd_valid && !upd_taken |-> wr_hist != 2'd0); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    upd_valid && upd_hit && !upd_taken && old_hist == HIST_MAX |-> wr_hist == HIST_MAX); // R7

endmodule

// File: rtl/bdp_top.sv
module bdp_top
  import bdp_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = PC_W - IDX_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            lk_backward,
  output logic            lk_hit,
  output logic            lk_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             ra_valid, rb_valid;
  logic [TAG_W-1:0] ra_tag, rb_tag;
  hist_t            ra_hist, rb_hist;
  logic             wr_en, upd_hit;
  hist_t            wr_hist;

  assign lk_idx = lk_pc[IDX_W-1:0];
  assign lk_tag = lk_pc[PC_W-1:IDX_W];
  assign up_idx = upd_pc[IDX_W-1:0];
  assign up_tag = upd_pc[PC_W-1:IDX_W];

  bdp_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_table (
    .clk(clk), .rst(rst),
    .ra_idx(lk_idx), .ra_valid(ra_valid), .ra_tag(ra_tag), .ra_hist(ra_hist),
    .rb_idx(up_idx), .rb_valid(rb_valid), .rb_tag(rb_tag), .rb_hist(rb_hist),
    .wr_en(wr_en), .wr_idx(up_idx), .wr_tag(up_tag), .wr_hist(wr_hist)
  );

  bdp_lookup #(.TAG_W(TAG_W)) u_lookup (
    .clk(clk), .rst(rst),
    .ent_valid(ra_valid), .ent_tag(ra_tag), .ent_hist(ra_hist),
    .req_tag(lk_tag), .backward(lk_backward),
    .hit(lk_hit), .taken(lk_taken)
  );

  bdp_update #(.TAG_W(TAG_W)) u_update (
    .clk(clk), .rst(rst),
    .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_tag(up_tag),
    .old_valid(rb_valid), .old_tag(rb_tag), .old_hist(rb_hist),
    .upd_hit(upd_hit), .wr_en(wr_en), .wr_hist(wr_hist)
  );

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit); // R1

  AST_TAKEN_THEN_HIT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(upd_valid) && $past(upd_taken) && lk_pc == $past(upd_pc)
      |-> lk_hit && lk_taken); // R8

  AST_FWD_MISS_NT: assert property (@(posedge clk) disable iff (rst)
    !lk_hit && !lk_backward |-> !lk_taken); // R2

endmodule

// File: tb/tb_bdp_top.sv
module tb_bdp_top;
  localparam int CLK_PERIOD = 10;
  localparam int PCW = 8;
  localparam int NENT = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [PCW-1:0] lk_pc = '0;
  logic           lk_backward = 1'b0;
  logic           lk_hit, lk_taken;
  logic           upd_valid = 1'b0;
  logic [PCW-1:0] upd_pc = '0;
  logic           upd_taken = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // reference table
  bit       m_v   [NENT];
  bit [4:0] m_tag [NENT];
  int       m_h   [NENT];

  always #(CLK_PERIOD/2) clk = ~clk;

  bdp_top #(.PC_W(PCW), .ENTRIES(NENT)) dut (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_backward(lk_backward),
    .lk_hit(lk_hit), .lk_taken(lk_taken), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  task automatic model_update(input int pc, input bit t);
    int i = pc % NENT;
    bit [4:0] tg = 5'(pc / NENT);
    if (m_v[i] && m_tag[i] == tg) begin
      if (t) m_h[i] = 0;
      else if (m_h[i] < 3) m_h[i] = m_h[i] + 1;
    end else begin
      m_v[i] = 1; m_tag[i] = tg; m_h[i] = t ? 0 : 1;
    end
  endtask

  // one cycle: drive lookup (+ optional update), check lookup vs pre-edge model
  task automatic step(input string sec, input int lpc, input bit bw,
                      input bit uv, input int upc, input bit ut);
    int i;
    bit eh, et;
    string kind;
    @(negedge clk);
    lk_pc = PCW'(lpc); lk_backward = bw;
    upd_valid = uv; upd_pc = PCW'(upc); upd_taken = ut;
    #(CLK_PERIOD/4);
    i = lpc % NENT;
    eh = m_v[i] && m_tag[i] == 5'(lpc / NENT);
    if (eh) begin et = (m_h[i] != 3); kind = et ? "R4" : "R5"; end
    else    begin et = bw;            kind = bw ? "R3" : "R2"; end
    n_checks++;
    if (lk_hit !== eh || lk_taken !== et) begin
      n_fail++;
      $display("FAIL %s/%s pc=%0d actual hit=%b taken=%b expected hit=%b taken=%b",
               sec, kind, lpc, lk_hit, lk_taken, eh, et);
    end
    if (uv) model_update(upc, ut);
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NENT; i++) begin m_v[i] = 0; m_tag[i] = '0; m_h[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: after reset every address misses, static rule in both directions (R2, R3)
    for (int p = 0; p < 256; p++) begin
      step("R1", p, 1'b0, 1'b0, 0, 1'b0);
      step("R1", p, 1'b1, 1'b0, 0, 1'b0);
    end

    // R8: claim via not-taken (history 1), then two more not-taken reach 3 (R7, R5)
    step("R8", 8'h21, 1'b0, 1'b1, 8'h21, 1'b0);
    step("R8", 8'h21, 1'b0, 1'b0, 0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      step("R7", 8'h21, 1'b0, 1'b1, 8'h21, 1'b0);
      step("R7", 8'h21, 1'b1, 1'b0, 0, 1'b0);
    end
    // R6: a taken resolution clears the saturated history
    step("R6", 8'h21, 1'b0, 1'b1, 8'h21, 1'b1);
    step("R6", 8'h21, 1'b0, 1'b0, 0, 1'b0);

    // nested loops: inner backward branch, outer backward branch; same-cycle
    // lookup+update of the same address exercises R10
    for (int o = 0; o < 4; o++) begin
      for (int n = 0; n < 5; n++)
        step("R10", 8'h46, 1'b1, 1'b1, 8'h46, n < 4);
      step("R10", 8'h5B, 1'b1, 1'b1, 8'h5B, o < 3);
    end
    // forward branch alternating outcomes
    for (int k = 0; k < 8; k++)
      step("R4", 8'h33, 1'b0, 1'b1, 8'h33, k[0]);
    // forward branch never taken: reaches 3 and is predicted not taken
    for (int k = 0; k < 6; k++)
      step("R5", 8'h12, 1'b0, 1'b1, 8'h12, 1'b0);

    // R9: aliasing on slot 5
    step("R9", 8'h05, 1'b1, 1'b1, 8'h05, 1'b1);
    step("R9", 8'h05, 1'b0, 1'b0, 0, 1'b0);
    step("R9", 8'h0D, 1'b0, 1'b1, 8'h0D, 1'b0);
    step("R9", 8'h05, 1'b1, 1'b0, 0, 1'b0);
    step("R9", 8'h0D, 1'b1, 1'b0, 0, 1'b0);
    step("R9", 8'hFD, 1'b0, 1'b0, 0, 1'b0);

    // sweep all addresses again against the model
    for (int p = 0; p < 256; p++) step("R4", p, p[0], 1'b0, 0, 1'b0);

    // R1: reset again empties the table
    @(negedge clk); rst = 1'b1; upd_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < NENT; i++) m_v[i] = 0;
    for (int p = 0; p < 16; p++) step("R1", p * 16 + 5, 1'b1, 1'b0, 0, 1'b0);

    idle_cycle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule